// File: doc/BRIEF.md
# H-Bridge Mode and Fault Supervisor

This block sits between a host's two direction pins and the gate drivers of a single full bridge. It turns the pin pair into one of four bridge modes (coast, reverse, forward, brake) and presents, for each bridge leg, whether that leg is pulled high, pulled low or left floating. It also tells the PWM duty generator when to run and when to restart its soft ramp from zero.

All protection decisions are made here. Four fault classes are supervised, and each recovers in its own way:

- A sustained current-limit condition raises an alarm but lets driving continue, and it clears by itself.
- A deglitched short-circuit condition shuts the bridge off and stays latched until the supply drops out.
- Over-temperature shuts the bridge off until the flag falls.
- Undervoltage resets the whole block.

The alarm output is active low and also pulses low each time the bridge wakes from sleep. Analog sensing happens outside the block: every flag arrives as a synchronous, already-compared logic level. The persistence and deglitch windows are cycle counters derived from the clock frequency parameter. The control pins are plain levels with no handshake, because nothing streams through the block.

Top module: `hb_supervisor`

## Requirements
- R1: The pin pair {dir_a, dir_b} selects the mode: 00 coast, 01 reverse (leg A low, leg B high), 10 forward (leg A high, leg B low), 11 brake (both legs high). The leg codes are 00 floating, 01 low and 10 high. Legs follow the pins one clock after they are sampled.
- R2: In coast with no fault present, both legs float, sleep_active is 1, pwm_run is 0 and alarm_n is 1. This is also the state held while rst_n is low.
- R3: A current-limit flag held for LIMIT_PERSIST_US microseconds' worth of consecutive cycles while the bridge is awake drives alarm_n low while the legs keep driving. alarm_n returns high one cycle after the flag drops.
- R4: Sampling pins 00 clears the current-limit persistence count, so the full window must elapse again after waking.
- R5: An overcurrent flag held for OC_DEGLITCH_US microseconds' worth of consecutive cycles floats both legs and drives alarm_n low. One cycle fewer has no effect.
- R6: The overcurrent shutdown stays in force after the flag drops and through coast, and only undervoltage releases it.
- R7: While the over-temperature flag is sampled high, both legs float and alarm_n is low. Driving resumes one cycle after the flag is sampled low.
- R8: While undervoltage is sampled high, all legs float, alarm_n is low and pwm_run, pwm_restart and sleep_active are 0. All timers, the overcurrent latch and the mode are reset.
- R9: Every move from coast into a non-coast mode holds alarm_n low for exactly WAKE_PULSE_US microseconds' worth of cycles. The pulse is cut short if the pins return to 00, and leaving brake gives no pulse.
- R10: pwm_restart is a one-cycle pulse, aligned with the new mode, when forward or reverse is entered from coast or brake. Switching between forward and reverse gives no pulse.
- R11: Precedence is undervoltage over latched overcurrent over over-temperature over sleep over normal decoding, so a fault suppresses sleep_active.
- R12: pwm_run is 1 only in forward or reverse with no disabling fault, and never in brake or coast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| dir_a | input | 1 | Direction pin A (high drives leg A high) |
| dir_b | input | 1 | Direction pin B (high drives leg B high) |
| cur_limit_flag | input | 1 | Qualified current-limit comparator level |
| overcurrent_raw | input | 1 | Raw short-circuit detector level |
| overtemp_flag | input | 1 | Over-temperature level, hysteresis applied outside |
| undervolt_flag | input | 1 | Supply below lockout threshold |
| leg_a_drv | output | 2 | Leg A state: 00 floating, 01 low, 10 high |
| leg_b_drv | output | 2 | Leg B state: 00 floating, 01 low, 10 high |
| pwm_run | output | 1 | Enables the PWM duty generator |
| pwm_restart | output | 1 | One-cycle strobe restarting the duty ramp |
| sleep_active | output | 1 | Bridge is in low-power coast |
| alarm_n | output | 1 | Active-low fault indication for an open-drain pad |

## Verification
The bound checker watches, on every cycle, the one-cycle response to the mode pins, the forced shutdown and alarm under undervoltage and over-temperature, the quiet state of sleep, the single-cycle width of the restart strobe, and that pwm_run only appears with opposite driven legs. The time-based behaviours need the bench's directed scenarios. These are the exact persistence and deglitch boundaries one cycle either side, the stickiness of the overcurrent latch through coast, its release by undervoltage, the clearing of the current-limit count in coast, and the exact width of the wake pulse.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Mode encoding equals the sampled pin pair {dir_a, dir_b}.
  typedef enum logic [1:0] {
    MODE_COAST = 2'b00,
    MODE_REV   = 2'b01,
    MODE_FWD   = 2'b10,
    MODE_BRAKE = 2'b11
  } hb_mode_e;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_LOW  = 2'b01,
    LEG_HIGH = 2'b10
  } hb_leg_e;

  function automatic logic mode_drives(hb_mode_e m);
    return (m == MODE_FWD) || (m == MODE_REV);
  endfunction

endpackage

// File: rtl/hb_persist_timer.sv
// Counts consecutive cycles of a qualifying flag; done once LIMIT is reached.
module hb_persist_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flag,
  output logic done
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !flag) begin
      cnt_q <= '0;
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == TOP);
endmodule

// File: rtl/hb_wake_pulse.sv
// Holds active for LEN cycles after start; clr cancels it.
module hb_wake_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic active
);
  localparam int unsigned W = $clog2(LEN + 1);
  localparam logic [W-1:0] TOP = W'(LEN);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= TOP;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/hb_mode_tracker.sv
// Registers the requested mode and detects wake and ramp-restart events.
module hb_mode_tracker
  import hb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     uv,
  input  logic     dir_a,
  input  logic     dir_b,
  output hb_mode_e mode_q,
  output logic     restart_q,
  output logic     wake_start,
  output logic     req_sleep
);
  hb_mode_e req;

  assign req        = hb_mode_e'({dir_a, dir_b});
  assign req_sleep  = (req == MODE_COAST);
  assign wake_start = !uv && (mode_q == MODE_COAST) && !req_sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_COAST;
      restart_q <= 1'b0;
    end else begin
      mode_q    <= uv ? MODE_COAST : req;
      restart_q <= !uv && mode_drives(req) &&
                   ((mode_q == MODE_COAST) || (mode_q == MODE_BRAKE));
    end
  end
endmodule

// File: rtl/hb_output_stage.sv
// Resolves fault precedence into leg states, run, sleep and alarm.
module hb_output_stage
  import hb_pkg::*;
(
  input  logic     uv_q,
  input  logic     oc_lat,
  input  logic     ot_q,
  input  logic     ilim_fault,
  input  logic     wake_active,
  input  hb_mode_e mode,
  output hb_leg_e  leg_a,
  output hb_leg_e  leg_b,
  output logic     run,
  output logic     sleep,
  output logic     alarm_n
);
  logic bridge_off;

  assign bridge_off = uv_q || oc_lat || ot_q;

  always_comb begin
    leg_a = LEG_OFF;
    leg_b = LEG_OFF;
    run   = 1'b0;
    sleep = 1'b0;
    if (!bridge_off) begin
      unique case (mode)
        MODE_COAST: sleep = 1'b1;
        MODE_REV: begin
          leg_a = LEG_LOW;
          leg_b = LEG_HIGH;
          run   = 1'b1;
        end
        MODE_FWD: begin
          leg_a = LEG_HIGH;
          leg_b = LEG_LOW;
          run   = 1'b1;
        end
        MODE_BRAKE: begin
          leg_a = LEG_HIGH;
          leg_b = LEG_HIGH;
        end
        default: sleep = 1'b0;
      endcase
    end
  end

  assign alarm_n = !(bridge_off || ilim_fault || wake_active);
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int unsigned CLK_HZ           = 50_000_000,
  parameter int unsigned LIMIT_PERSIST_US = 275_000,
  parameter int unsigned OC_DEGLITCH_US   = 3,
  parameter int unsigned WAKE_PULSE_US    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic       cur_limit_flag,
  input  logic       overcurrent_raw,
  input  logic       overtemp_flag,
  input  logic       undervolt_flag,
  output logic [1:0] leg_a_drv,
  output logic [1:0] leg_b_drv,
  output logic       pwm_run,
  output logic       pwm_restart,
  output logic       sleep_active,
  output logic       alarm_n
);
  localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned LIM_RAW    = CYC_PER_US * LIMIT_PERSIST_US;
  localparam int unsigned OC_RAW     = CYC_PER_US * OC_DEGLITCH_US;
  localparam int unsigned WAKE_RAW   = CYC_PER_US * WAKE_PULSE_US;
  localparam int unsigned LIM_CYC    = (LIM_RAW  > 0) ? LIM_RAW  : 1;
  localparam int unsigned OC_CYC     = (OC_RAW   > 0) ? OC_RAW   : 1;
  localparam int unsigned WAKE_CYC   = (WAKE_RAW > 0) ? WAKE_RAW : 1;

  hb_mode_e mode_q;
  hb_leg_e  leg_a, leg_b;
  logic     restart_q, wake_start, req_sleep;
  logic     ilim_fault, oc_done, wake_active;
  logic     oc_lat_q, ot_q, uv_q;

  hb_mode_tracker u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv        (undervolt_flag),
    .dir_a     (dir_a),
    .dir_b     (dir_b),
    .mode_q    (mode_q),
    .restart_q (restart_q),
    .wake_start(wake_start),
    .req_sleep (req_sleep)
  );

  // Current-limit persistence: cleared by sleep request or undervoltage.
  hb_persist_timer #(.LIMIT(LIM_CYC)) u_ilim_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (undervolt_flag || req_sleep),
    .flag (cur_limit_flag),
    .done (ilim_fault)
  );

  // Short-circuit deglitch: only undervoltage clears it.
  hb_persist_timer #(.LIMIT(OC_CYC)) u_oc_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (undervolt_flag),
    .flag (overcurrent_raw),
    .done (oc_done)
  );

  hb_wake_pulse #(.LEN(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (undervolt_flag || req_sleep),
    .start (wake_start),
    .active(wake_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lat_q <= 1'b0;
      ot_q     <= 1'b0;
      uv_q     <= 1'b0;
    end else begin
      oc_lat_q <= !undervolt_flag && (oc_lat_q || oc_done);
      ot_q     <= !undervolt_flag && overtemp_flag;
      uv_q     <= undervolt_flag;
    end
  end

  hb_output_stage u_out (
    .uv_q       (uv_q),
    .oc_lat     (oc_lat_q),
    .ot_q       (ot_q),
    .ilim_fault (ilim_fault),
    .wake_active(wake_active),
    .mode       (mode_q),
    .leg_a      (leg_a),
    .leg_b      (leg_b),
    .run        (pwm_run),
    .sleep      (sleep_active),
    .alarm_n    (alarm_n)
  );

  assign leg_a_drv   = leg_a;
  assign leg_b_drv   = leg_b;
  assign pwm_restart = restart_q;
endmodule

// File: rtl/hb_supervisor_checker.sv
module hb_supervisor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_a,
  input logic       dir_b,
  input logic       overtemp_flag,
  input logic       undervolt_flag,
  input logic [1:0] leg_a_drv,
  input logic [1:0] leg_b_drv,
  input logic       pwm_run,
  input logic       pwm_restart,
  input logic       sleep_active,
  input logic       alarm_n
);
  p_fwd_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_a && !dir_b) |=> (!alarm_n || (leg_a_drv == 2'b10 && leg_b_drv == 2'b01)));

  p_rev_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_a && dir_b) |=> (!alarm_n || (leg_a_drv == 2'b01 && leg_b_drv == 2'b10)));

  p_brake_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_a && dir_b) |=> (!alarm_n || (leg_a_drv == 2'b10 && leg_b_drv == 2'b10)));

  p_coast_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_a && !dir_b) |=> (sleep_active || !alarm_n));

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_active |-> (alarm_n && leg_a_drv == 2'b00 && leg_b_drv == 2'b00 && !pwm_run));

  p_overtemp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp_flag |=> (!alarm_n && leg_a_drv == 2'b00 && leg_b_drv == 2'b00 && !pwm_run));

  p_undervolt_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    undervolt_flag |=> (!alarm_n && leg_a_drv == 2'b00 && leg_b_drv == 2'b00 &&
                        !pwm_run && !pwm_restart && !sleep_active));

  p_restart_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_restart |=> !pwm_restart);

  p_run_drives_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_run |-> (leg_a_drv != leg_b_drv && leg_a_drv != 2'b00 && leg_b_drv != 2'b00));
endmodule

bind hb_supervisor hb_supervisor_checker u_hb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dir_a         (dir_a),
  .dir_b         (dir_b),
  .overtemp_flag (overtemp_flag),
  .undervolt_flag(undervolt_flag),
  .leg_a_drv     (leg_a_drv),
  .leg_b_drv     (leg_b_drv),
  .pwm_run       (pwm_run),
  .pwm_restart   (pwm_restart),
  .sleep_active  (sleep_active),
  .alarm_n       (alarm_n)
);

// File: tb/hb_supervisor_bench.sv
module hb_supervisor_bench;
  // One cycle per microsecond keeps the timer windows short.
  localparam int LIM  = 40;
  localparam int OC   = 3;
  localparam int WAKE = 4;

  // Entry: {dir_a, dir_b, ot, exp_a[1:0], exp_b[1:0], exp_sleep, exp_run}
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_0_10_01_0_1,
    9'b0_1_0_01_10_0_1,
    9'b1_1_0_10_10_0_0,
    9'b1_0_0_10_01_0_1,
    9'b0_0_0_00_00_1_0,
    9'b0_1_1_00_00_0_0,
    9'b0_1_0_01_10_0_1,
    9'b1_1_1_00_00_0_0,
    9'b0_0_0_00_00_1_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0;
  logic ilim = 1'b0, oc = 1'b0, ot = 1'b0, uv = 1'b0;
  logic [1:0] leg_a, leg_b;
  logic run, restart, sleep_o, alarm_n;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hb_supervisor #(
    .CLK_HZ          (1_000_000),
    .LIMIT_PERSIST_US(LIM),
    .OC_DEGLITCH_US  (OC),
    .WAKE_PULSE_US   (WAKE)
  ) u_hb_supervisor (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir_a          (dir_a),
    .dir_b          (dir_b),
    .cur_limit_flag (ilim),
    .overcurrent_raw(oc),
    .overtemp_flag  (ot),
    .undervolt_flag (uv),
    .leg_a_drv      (leg_a),
    .leg_b_drv      (leg_b),
    .pwm_run        (run),
    .pwm_restart    (restart),
    .sleep_active   (sleep_o),
    .alarm_n        (alarm_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_dir(input logic a, input logic b);
    dir_a = a;
    dir_b = b;
  endtask

  initial begin
    step(3);
    chk("R2 reset leg A", leg_a, 0);
    chk("R2 reset leg B", leg_b, 0);
    chk("R2 reset sleep", sleep_o, 1);
    chk("R2 reset alarm_n", alarm_n, 1);
    chk("R2 reset run", run, 0);
    chk("R10 reset restart", restart, 0);
    rst_n = 1'b1;
    step(2);

    // Table walk: decode, sleep, over-temperature masking, run.
    for (int i = 0; i < NV; i++) begin
      set_dir(VEC[i][8], VEC[i][7]);
      ot = VEC[i][6];
      step(WAKE + 2);
      chk("R1 table leg A", leg_a, VEC[i][5:4]);
      chk("R1 table leg B", leg_b, VEC[i][3:2]);
      chk("R2 table sleep", sleep_o, VEC[i][1]);
      chk("R12 table run", run, VEC[i][0]);
    end
    ot = 1'b0;
    step(2);

    // R9 / R10: wake from coast into forward.
    set_dir(1'b1, 1'b0);
    step(1);
    chk("R10 restart on wake", restart, 1);
    for (int k = 0; k < WAKE; k++) begin
      chk("R9 wake pulse low", alarm_n, 0);
      if (k == 1) chk("R10 restart one cycle", restart, 0);
      step(1);
    end
    chk("R9 wake pulse ended", alarm_n, 1);

    set_dir(1'b0, 1'b1);
    step(1);
    chk("R10 no restart fwd to rev", restart, 0);
    chk("R9 no pulse fwd to rev", alarm_n, 1);
    set_dir(1'b1, 1'b1);
    step(1);
    chk("R10 no restart into brake", restart, 0);
    set_dir(1'b1, 1'b0);
    step(1);
    chk("R10 restart brake to fwd", restart, 1);
    chk("R9 no pulse leaving brake", alarm_n, 1);
    step(2);

    // R3: current-limit persistence boundary.
    ilim = 1'b1;
    step(LIM - 1);
    chk("R3 limit one short", alarm_n, 1);
    step(1);
    chk("R3 limit alarm", alarm_n, 0);
    chk("R3 still driving", leg_a, 2);
    chk("R3 run kept", run, 1);
    ilim = 1'b0;
    step(1);
    chk("R3 self clear", alarm_n, 1);

    // R4: coast clears the persistence count.
    ilim = 1'b1;
    step(LIM - 5);
    set_dir(1'b0, 1'b0);
    step(2);
    chk("R4 sleep during limit", sleep_o, 1);
    chk("R4 no alarm in sleep", alarm_n, 1);
    set_dir(1'b1, 1'b0);
    step(LIM - 1);
    chk("R4 window restarted", alarm_n, 1);
    step(1);
    chk("R4 trips after full window", alarm_n, 0);
    ilim = 1'b0;
    step(2);

    // R5 / R6: overcurrent deglitch and latch.
    oc = 1'b1;
    step(OC - 1);
    oc = 1'b0;
    step(3);
    chk("R5 short glitch ignored alarm", alarm_n, 1);
    chk("R5 short glitch ignored leg", leg_a, 2);
    oc = 1'b1;
    step(OC);
    oc = 1'b0;
    step(1);
    chk("R5 latched alarm", alarm_n, 0);
    chk("R5 latched leg A", leg_a, 0);
    chk("R5 latched leg B", leg_b, 0);
    chk("R5 latched run", run, 0);
    step(5);
    chk("R6 latch holds", leg_a, 0);
    set_dir(1'b0, 1'b0);
    step(2);
    chk("R11 latch over sleep", sleep_o, 0);
    chk("R6 alarm through coast", alarm_n, 0);
    set_dir(1'b1, 1'b0);
    step(2);
    chk("R6 latch after coast", leg_a, 0);

    // R8: undervoltage resets everything.
    uv = 1'b1;
    step(1);
    chk("R8 uv alarm", alarm_n, 0);
    chk("R8 uv leg A", leg_a, 0);
    chk("R8 uv leg B", leg_b, 0);
    chk("R8 uv run", run, 0);
    set_dir(1'b0, 1'b0);
    step(1);
    chk("R11 uv over sleep", sleep_o, 0);
    set_dir(1'b1, 1'b0);
    uv = 1'b0;
    step(1);
    chk("R8 latch released", leg_a, 2);
    chk("R10 restart after uv", restart, 1);
    chk("R9 pulse after uv", alarm_n, 0);
    step(WAKE);
    chk("R8 alarm clear after uv", alarm_n, 1);

    // R7: over-temperature with automatic resume.
    ot = 1'b1;
    step(1);
    chk("R7 ot leg A", leg_a, 0);
    chk("R7 ot alarm", alarm_n, 0);
    chk("R7 ot run", run, 0);
    ot = 1'b0;
    step(1);
    chk("R7 resume leg A", leg_a, 2);
    chk("R7 resume alarm", alarm_n, 1);
    ot = 1'b1;
    set_dir(1'b0, 1'b0);
    step(1);
    chk("R11 ot over sleep", sleep_o, 0);
    chk("R11 ot alarm in coast", alarm_n, 0);
    ot = 1'b0;
    step(1);
    chk("R2 sleep after ot", sleep_o, 1);
    chk("R2 alarm after ot", alarm_n, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule